// File: doc/BRIEF.md
# Configuration Clock Pacer

This block drives the configuration clock and the parallel data pins of a device that loads its setup from a 16-bit or 32-bit word stream. Each word taken from a valid/ready stream goes to the data pins and stays there for a number of clock pulses. That number is picked by a two-bit code that gives the base-2 logarithm of the pulses per word. Each clock pulse lasts two system cycles: one cycle high and one cycle low. When the word is narrow, the upper half of the pins is driven to zero.

The block also has a standalone mode. A count write makes the block emit that many clock pulses with no new data. The pins keep the last word during these pulses. When the run ends, a sticky done flag is set. Writing 1 to the clear input drops the flag. A new count write drops the flag at once, so a completion left over from an earlier run can never be read as the end of the new one. Software can also push all-ones filler words at the single-pulse code to keep the clock running while it waits for the target to come up.

A single enable gates all clock and data activity. While the enable is low, the block makes no clock edges, takes no word and freezes its current window. It does this even when data or a count is waiting.

Top module: `ccg_top`

## Requirements
- R1: After reset `dclk` is 0, `done` is 0, `pin_data` is all zeros, and `s_ready` equals `cfg_en`.
- R2: A word is taken on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` then stays 0 for exactly 2·N cycles, where N is the pulse count of that word. `s_ready` is never 1 while a window or a free run is active.
- R3: The pulse count per word is 2 raised to `ratio_code`: code 0 gives 1 pulse, 1 gives 2, 2 gives 4, 3 gives 8. The code is sampled only on the edge where the word is taken; later changes to the code have no effect on that word.
- R4: Each `dclk` pulse is one system cycle high followed by at least one cycle low. While a window or run is active and `cfg_en` is 1, pulses follow each other every two cycles.
- R5: From the edge where a word is taken, `pin_data` shows the word. When `wide_bus` is 1 the whole word is shown. When `wide_bus` is 0, only the low half is shown and the upper half is zero. `pin_data` changes only when a word is taken. All-ones filler words at code 0 give one pulse each, with all pins high.
- R6: While `cfg_en` is 0, `dclk` and `s_ready` are 0. The pulses still owed by a word window or a free run are all emitted later, once `cfg_en` returns to 1.
- R7: A `cnt_wr` with a nonzero `cnt_val` N emits exactly N `dclk` pulses. No word is taken until the run has finished.
- R8: `done` becomes 1 on the edge that ends the last pulse of a free run. It stays 1 until `done_clr` is 1 on an edge with no `cnt_wr` and no completion on that same edge. A completion takes priority over a clear on the same edge.
- R9: Any `cnt_wr` with a nonzero value makes `done` 0 on the next cycle, even if `done` was 1.
- R10: A `cnt_wr` with a `cnt_val` of 0 makes `done` 1 on the next cycle and emits no pulse.
- R11: A `cnt_wr` that arrives during a word window does not cut the window short. The window finishes first. After one idle cycle, the free pulses begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Enable for the clock and data paths |
| ratio_code | input | 2 | Base-2 logarithm of the pulses per word |
| wide_bus | input | 1 | 1 selects the full-width bus, 0 selects the half-width bus |
| s_valid | input | 1 | A word is offered |
| s_ready | output | 1 | The block takes a word on this edge |
| s_data | input | DATA_W | Offered word |
| cnt_wr | input | 1 | Write strobe for the free-pulse count |
| cnt_val | input | CNT_W | Number of free pulses |
| done_clr | input | 1 | Writing 1 clears the done flag |
| done | output | 1 | Sticky flag: free run finished |
| dclk | output | 1 | Configuration clock to the pin |
| pin_data | output | DATA_W | Parallel data to the pins |

## Verification
The bench builds the block with a 32-bit word and an 8-bit count. The 8-bit count makes the largest count, 255, cheap to run, so the top end of the count range is exercised alongside counts of zero and one. With the 32-bit word, both bus modes can be tested: the halved narrow view and the full view. Random words with random codes and random bus widths are mixed with directed cases. These cases are an enable dropped in the middle of a window, a count written during a window, a count written while the enable is low, and a stale done flag that a new count write must clear.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int RATIO_W = 2;
  // the largest pulse count, 2**(2**RATIO_W-1), fits in 2**RATIO_W bits
  localparam int HOLD_W  = (1 << RATIO_W);

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_DATA = 2'd1,
    MODE_FREE = 2'd2
  } mode_t;

  // pulses per word for a log2 ratio code
  function automatic logic [HOLD_W-1:0] pulses_for(input logic [RATIO_W-1:0] code);
    pulses_for = {{(HOLD_W-1){1'b0}}, 1'b1} << code;
  endfunction
endpackage

// File: rtl/ccg_phase.sv
// Two-cycle pulse phase: 0 = clock high, 1 = clock low.
module ccg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic phase,
  output logic pulse_end
);
  assign pulse_end = step & phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b0;
    else if (load) phase <= 1'b0;
    else if (step) phase <= ~phase;
  end
endmodule

// File: rtl/ccg_status.sv
// Free-pulse counter and sticky completion flag.
module ccg_status #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             done_clr,
  input  logic             free_tick,
  output logic             free_pend,
  output logic             free_done,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] free_left;

  assign free_done = free_tick & ~cnt_wr & (free_left == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_left <= '0;
      free_pend <= 1'b0;
      done      <= 1'b0;
    end else if (cnt_wr) begin
      free_left <= cnt_val;
      free_pend <= |cnt_val;
      done      <= ~|cnt_val;
    end else begin
      if (free_tick) free_left <= free_left - ONE;
      if (free_done) begin
        free_pend <= 1'b0;
        done      <= 1'b1;
      end else if (done_clr) begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ccg_top.sv
module ccg_top
  import ccg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [RATIO_W-1:0] ratio_code,
  input  logic               wide_bus,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               done_clr,
  output logic               done,
  output logic               dclk,
  output logic [DATA_W-1:0]  pin_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [HOLD_W-1:0] HOLD_ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

  // narrow mode keeps the low half and zeroes the rest
  function automatic logic [DATA_W-1:0] fmt_word(input logic [DATA_W-1:0] d, input logic wide);
    fmt_word = wide ? d : {{(DATA_W-HALF_W){1'b0}}, d[HALF_W-1:0]};
  endfunction

  mode_t             mode;
  logic [HOLD_W-1:0] hold_left;
  logic [DATA_W-1:0] word_q;
  logic              phase, pulse_end, step, load_win;
  logic              accept, start_free, free_tick, free_pend, free_done;

  // named events
  assign step       = cfg_en & ((mode == MODE_DATA) | ((mode == MODE_FREE) & free_pend));
  assign s_ready    = (mode == MODE_IDLE) & cfg_en & ~free_pend;
  assign accept     = s_ready & s_valid;
  assign start_free = (mode == MODE_IDLE) & cfg_en & free_pend;
  assign load_win   = accept | start_free;
  assign free_tick  = pulse_end & (mode == MODE_FREE);
  assign dclk       = step & ~phase;
  assign pin_data   = word_q;

  ccg_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_win),
    .step     (step),
    .phase    (phase),
    .pulse_end(pulse_end)
  );

  ccg_status #(.CNT_W(CNT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_wr   (cnt_wr),
    .cnt_val  (cnt_val),
    .done_clr (done_clr),
    .free_tick(free_tick),
    .free_pend(free_pend),
    .free_done(free_done),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_IDLE;
      hold_left <= '0;
      word_q    <= '0;
    end else begin
      unique case (mode)
        MODE_IDLE: begin
          if (start_free) begin
            mode <= MODE_FREE;
          end else if (accept) begin
            mode      <= MODE_DATA;
            hold_left <= pulses_for(ratio_code);
            word_q    <= fmt_word(s_data, wide_bus);
          end
        end
        MODE_DATA: begin
          if (pulse_end) begin
            if (hold_left == HOLD_ONE) mode <= MODE_IDLE;
            else                       hold_left <= hold_left - HOLD_ONE;
          end
        end
        MODE_FREE: begin
          if (!free_pend) mode <= MODE_IDLE;
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccg_checker.sv
module ccg_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              s_valid,
  input logic              s_ready,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              done_clr,
  input logic              done,
  input logic              dclk,
  input logic [DATA_W-1:0] pin_data,
  input logic              free_done
);
  // R6: enable low silences clock and stream
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (!dclk && !s_ready));

  // R4: a high cycle is always followed by a low one
  a_r4_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);

  // R2: no clock while a word may be taken; taking one closes the stream
  a_r2_no_clock_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !dclk);
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R5: pins move only when a word is taken
  a_r5_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(pin_data));

  // R9: nonzero count write clears done
  a_r9_stale_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_val != '0) |=> !done);

  // R10: zero count sets done at once
  a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_val == '0) |=> done);

  // R8: sticky and write-1-to-clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr && !cnt_wr) |=> done);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !cnt_wr && !free_done) |=> !done);
  a_r8_completion_sets: assert property (@(posedge clk) disable iff (!rst_n)
    free_done |=> done);
endmodule

bind ccg_top ccg_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ccg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .cnt_wr   (cnt_wr),
  .cnt_val  (cnt_val),
  .done_clr (done_clr),
  .done     (done),
  .dclk     (dclk),
  .pin_data (pin_data),
  .free_done(free_done)
);

// File: tb/ccg_top_bench.sv
module ccg_top_bench;
  localparam int DW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b1;
  logic [1:0]    ratio_code = '0;
  logic          wide_bus = 1'b1;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          cnt_wr = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          done_clr = 1'b0;
  logic          done, dclk;
  logic [DW-1:0] pin_data;

  int checks = 0;
  int fails = 0;
  int pulse_cnt = 0;
  logic [DW-1:0] exp_pin = '0;
  logic prev_dclk = 1'b0;

  always #10 clk = ~clk;

  ccg_top #(.DATA_W(DW), .CNT_W(CW)) u_ccg_top (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ratio_code(ratio_code),
    .wide_bus(wide_bus), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val), .done_clr(done_clr), .done(done),
    .dclk(dclk), .pin_data(pin_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_fmt(input logic [DW-1:0] d, input logic w);
    return w ? d : (d & 32'h0000_FFFF);
  endfunction

  function automatic int exp_pulses(input logic [1:0] code);
    return 1 << code;
  endfunction

  // monitor at the falling edge, half a cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (dclk) begin
        pulse_cnt++;
        check(pin_data === exp_pin, "R5 pins during pulse", pin_data, exp_pin);
        check(!prev_dclk, "R4 high lasts one cycle", 1, 0);
      end
      prev_dclk = dclk;
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // offer a word, wait for it to be taken; returns cycles until ready again
  task automatic send_word(input logic [DW-1:0] d, input logic [1:0] code, input logic w,
                           output int cycles);
    int n = 0;
    s_data = d; ratio_code = code; wide_bus = w; s_valid = 1'b1;
    while (!s_ready && n < 1000) begin tick(); n++; end
    exp_pin = exp_fmt(d, w);
    pulse_cnt = 0;
    tick();
    s_valid = 1'b0;
    ratio_code = 2'($urandom);          // R3: later code changes must not matter
    cycles = 0;
    while (!s_ready && cycles < 2000) begin tick(); cycles++; end
  endtask

  task automatic write_cnt(input logic [CW-1:0] v);
    cnt_val = v; cnt_wr = 1'b1;
    tick();
    cnt_wr = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 4000) begin
      check(!s_ready, "R7 no word taken during run", s_ready, 0);
      tick(); cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    logic [1:0] code;
    logic [DW-1:0] d;
    logic w;
    void'($urandom(32'd20250611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(dclk == 1'b0, "R1 dclk", dclk, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(pin_data == '0, "R1 pin_data", pin_data, 0);
    check(s_ready == 1'b1, "R1 ready follows enable", s_ready, 1);

    // R5 all-ones filler at code 0, full width
    for (int i = 0; i < 3; i++) begin
      send_word(32'hFFFF_FFFF, 2'd0, 1'b1, cyc);
      check(pulse_cnt == 1, "R5 filler one pulse", pulse_cnt, 1);
      check(pin_data == 32'hFFFF_FFFF, "R5 filler pins high", pin_data, 32'hFFFF_FFFF);
    end
    // R5 narrow bus
    send_word(32'hABCD_1234, 2'd1, 1'b0, cyc);
    check(pin_data == 32'h0000_1234, "R5 narrow upper half zero", pin_data, 32'h1234);

    // R2 R3 R4 random words
    for (int i = 0; i < 30; i++) begin
      code = 2'($urandom); d = $urandom; w = 1'($urandom);
      send_word(d, code, w, cyc);
      check(pulse_cnt == exp_pulses(code), "R3 pulses per word", pulse_cnt, exp_pulses(code));
      check(cyc == 2 * exp_pulses(code), "R2 R4 window length", cyc, 2 * exp_pulses(code));
    end

    // R6 enable dropped mid-window
    s_data = 32'h1357_9BDF; ratio_code = 2'd2; wide_bus = 1'b1; s_valid = 1'b1;
    while (!s_ready) tick();
    exp_pin = 32'h1357_9BDF; pulse_cnt = 0;
    tick(); s_valid = 1'b0;
    tick(); tick();
    cfg_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      check(dclk == 1'b0, "R6 no clock while disabled", dclk, 0);
      check(s_ready == 1'b0, "R6 no ready while disabled", s_ready, 0);
    end
    cfg_en = 1'b1;
    cyc = 0;
    while (!s_ready && cyc < 100) begin tick(); cyc++; end
    check(pulse_cnt == 4, "R6 owed pulses resume", pulse_cnt, 4);

    // R7 R8 free run
    pulse_cnt = 0;
    write_cnt(8'd5);
    check(done == 1'b0, "R9 done low after write", done, 0);
    wait_done(cyc);
    check(pulse_cnt == 5, "R7 free pulse count", pulse_cnt, 5);
    repeat (5) tick();
    check(done == 1'b1, "R8 done sticky", done, 1);
    done_clr = 1'b1; tick(); done_clr = 1'b0;
    check(done == 1'b0, "R8 write one clears", done, 0);

    // R7 largest count
    pulse_cnt = 0;
    write_cnt(8'd255);
    wait_done(cyc);
    check(pulse_cnt == 255, "R7 largest count", pulse_cnt, 255);

    // R10 zero count
    done_clr = 1'b1; tick(); done_clr = 1'b0;
    pulse_cnt = 0;
    write_cnt(8'd0);
    check(done == 1'b1, "R10 zero count done next cycle", done, 1);
    repeat (4) tick();
    check(pulse_cnt == 0, "R10 zero count no pulses", pulse_cnt, 0);

    // R9 stale done cleared by new count
    write_cnt(8'd3);
    check(done == 1'b0, "R9 stale done cleared", done, 0);
    pulse_cnt = 0;
    wait_done(cyc);
    check(pulse_cnt == 3, "R9 run after clear", pulse_cnt, 3);
    done_clr = 1'b1; tick(); done_clr = 1'b0;

    // R11 count written during a window
    s_data = 32'h0F0F_F0F0; ratio_code = 2'd3; wide_bus = 1'b1; s_valid = 1'b1;
    while (!s_ready) tick();
    exp_pin = 32'h0F0F_F0F0; pulse_cnt = 0;
    tick(); s_valid = 1'b0;
    write_cnt(8'd6);
    cyc = 2;
    while (!done && cyc < 200) begin
      check(!s_ready, "R11 no ready until run ends", s_ready, 0);
      tick(); cyc++;
    end
    check(pulse_cnt == 14, "R11 window then free pulses", pulse_cnt, 14);
    check(cyc == 30, "R11 done cycle", cyc, 30);
    done_clr = 1'b1; tick(); done_clr = 1'b0;

    // R6 count pending while disabled
    cfg_en = 1'b0;
    write_cnt(8'd3);
    pulse_cnt = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      check(dclk == 1'b0, "R6 pending count held", dclk, 0);
    end
    check(done == 1'b0, "R6 no completion while disabled", done, 0);
    cfg_en = 1'b1;
    wait_done(cyc);
    check(pulse_cnt == 3, "R6 pending count emitted", pulse_cnt, 3);

    summary();
    $finish;
  end
endmodule